// File: doc/BRIEF.md
# Keyed cache set-index hash

This block turns a memory address into a cache set index using a hash keyed by a stored random identifier. A cache that wants random placement loads a fresh key at each flush. That key reshuffles where every address lands, while the mapping stays fixed between loads. The hash does not take a slice of address bits.

The address is zero-extended to the next power-of-two width. Four rotated copies of it are made. Two rotate by amounts taken from two fields of the key. The other two rotate by amounts taken from two fields of the address just above the line offset. The four rotated copies, the padded address and the key are joined into one vector. That vector is XOR-folded down to the index width. The result is registered, with a valid flag one cycle behind the address strobe.

Top module: `cache_set_hash`

## Requirements
- R1: While rst_n is low at a clock edge, the stored key, idx and idx_valid are all cleared to zero.
- R2: idx_valid at each clock edge takes the value addr_valid had at that edge, so it lags addr_valid by exactly one cycle.
- R3: The address is zero-extended to PAD_W bits, the next power of two at or above ADDR_W. For defaults, and for the bench configuration (ADDR_W=20), this is 32 bits. Every rotation is taken modulo PAD_W.
- R4: Four left-rotated copies of the padded address are formed, each with a ROT_W = log2(PAD_W) bit amount. Copy c0 uses key[ROT_W-1:0]. Copy c1 uses key[2*ROT_W-1:ROT_W]. Copy c2 uses addr[OFFS_W+ROT_W-1:OFFS_W]. Copy c3 uses addr[OFFS_W+2*ROT_W-1:OFFS_W+ROT_W]. A left rotation by k moves input bit i to bit (i+k) mod PAD_W.
- R5: The fold input is {c0, c1, c2, c3, padded address, key}, with the key at the least significant end. Bit j of the index is the XOR of every fold-input bit whose position i satisfies i mod IDX_W = j. This is the same as XOR-ing IDX_W-wide chunks, with the last partial chunk zero-padded.
- R6: On an edge where key_load is high, key_in is stored as the key. Otherwise key_in is ignored and the stored key holds. Addresses sampled on the same edge as a load still hash with the previous key.
- R7: For a fixed address, loading a different key can change the resulting index.
- R8: With a zero key and both address rotate fields zero, the index equals the XOR fold of five copies of the padded address above a zero key field.
- R9: On an edge where addr_valid is high, idx takes the hash of addr and the stored key. When addr_valid is low, idx holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| key_load | input | 1 | Store key_in as the new key |
| key_in | input | KEY_W | Random key value |
| addr_valid | input | 1 | addr carries a lookup this cycle |
| addr | input | ADDR_W | Memory address to hash |
| idx_valid | output | 1 | idx holds a fresh result |
| idx | output | IDX_W | Registered set index |

## Verification
Each lookup's index and valid flag are due at the first clock edge after the address is presented. The bench drives inputs just after a falling edge and compares outputs at the next falling edge, which is one rising edge later. A key load takes effect on the rising edge that samples it, so the bench moves its model key only after comparing the result of any address sent on that same edge. Hold and ignore cases are checked through idx in the cycle right after the stimulus, before any new valid address.

// File: rtl/cache_hash_pkg.sv
package cache_hash_pkg;

    // smallest power of two not below w
    function automatic int pow2_ceil(int w);
        int p;
        p = 1;
        while (p < w) p = p * 2;
        return p;
    endfunction

    // number of bits needed to count 0..w-1 (w a power of two)
    function automatic int log2_of(int w);
        int n;
        n = 0;
        while ((1 << n) < w) n = n + 1;
        return n;
    endfunction

endpackage

// File: rtl/cache_hash_rotl.sv
module cache_hash_rotl #(
    parameter int W   = 32,
    parameter int AMT_W = 5
) (
    input  logic [W-1:0]     din,
    input  logic [AMT_W-1:0] amt,
    output logic [W-1:0]     dout
);
    logic [2*W-1:0] dbl;

    always_comb begin
        dbl  = {din, din} << amt;
        dout = dbl[2*W-1:W];
    end
endmodule

// File: rtl/cache_hash_fold.sv
module cache_hash_fold #(
    parameter int IN_W  = 192,
    parameter int OUT_W = 7
) (
    input  logic [IN_W-1:0]  din,
    output logic [OUT_W-1:0] dout
);
    localparam int NCHUNK = (IN_W + OUT_W - 1) / OUT_W;
    localparam int EXT_W  = NCHUNK * OUT_W;

    logic [EXT_W-1:0] ext;
    logic [OUT_W-1:0] acc;

    always_comb begin
        ext = '0;
        ext[IN_W-1:0] = din;
        acc = '0;
        for (int c = 0; c < NCHUNK; c++) begin
            acc = acc ^ ext[c*OUT_W +: OUT_W];
        end
        dout = acc;
    end
endmodule

// File: rtl/cache_set_hash.sv
module cache_set_hash
    import cache_hash_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int KEY_W  = 32,
    parameter int IDX_W  = 7,
    parameter int OFFS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              key_load,
    input  logic [KEY_W-1:0]  key_in,
    input  logic              addr_valid,
    input  logic [ADDR_W-1:0] addr,
    output logic              idx_valid,
    output logic [IDX_W-1:0]  idx
);
    localparam int PAD_W   = pow2_ceil(ADDR_W);
    localparam int ROT_W   = log2_of(PAD_W);
    localparam int NCOPY   = 4;
    localparam int FOLD_W  = (NCOPY + 1) * PAD_W + KEY_W;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [IDX_W-1:0] idx;
        logic             vld;
    } state_t;

    state_t state_d, state_q;

    logic [PAD_W-1:0]  addr_pad;
    logic [ROT_W-1:0]  rot_amt  [NCOPY];
    logic [PAD_W-1:0]  rot_copy [NCOPY];
    logic [FOLD_W-1:0] fold_in;
    logic [IDX_W-1:0]  hash_idx;
    logic [KEY_W-1:0]  key_cur;

    always_comb begin
        addr_pad = '0;
        addr_pad[ADDR_W-1:0] = addr;
    end

    // rotate amounts: two key fields, two address fields above the line offset
    assign rot_amt[0] = state_q.key[0     +: ROT_W];
    assign rot_amt[1] = state_q.key[ROT_W +: ROT_W];
    assign rot_amt[2] = addr[OFFS_W         +: ROT_W];
    assign rot_amt[3] = addr[OFFS_W + ROT_W +: ROT_W];

    for (genvar g = 0; g < NCOPY; g++) begin : g_rot
        cache_hash_rotl #(.W(PAD_W), .AMT_W(ROT_W)) u_rotl (
            .din  (addr_pad),
            .amt  (rot_amt[g]),
            .dout (rot_copy[g])
        );
    end

    assign fold_in = {rot_copy[0], rot_copy[1], rot_copy[2], rot_copy[3],
                      addr_pad, state_q.key};

    cache_hash_fold #(.IN_W(FOLD_W), .OUT_W(IDX_W)) u_fold (
        .din  (fold_in),
        .dout (hash_idx)
    );

    always_comb begin
        state_d = state_q;
        state_d.vld = addr_valid;
        if (addr_valid) state_d.idx = hash_idx;
        if (key_load)   state_d.key = key_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign key_cur   = state_q.key;
    assign idx_valid = state_q.vld;
    assign idx       = state_q.idx;
endmodule

// File: rtl/cache_set_hash_chk.sv
module cache_set_hash_chk #(
    parameter int KEY_W = 32,
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             key_load,
    input logic [KEY_W-1:0] key_in,
    input logic             addr_valid,
    input logic             idx_valid,
    input logic [IDX_W-1:0] idx,
    input logic [KEY_W-1:0] key_cur
);
    p_valid_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid |=> idx_valid);

    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> !idx_valid);

    p_idx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_valid |=> $stable(idx));

    p_key_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !key_load |=> $stable(key_cur));

    p_key_take_r6: assert property (@(posedge clk) disable iff (!rst_n)
        key_load |=> key_cur == $past(key_in));
endmodule

bind cache_set_hash cache_set_hash_chk #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_load   (key_load),
    .key_in     (key_in),
    .addr_valid (addr_valid),
    .idx_valid  (idx_valid),
    .idx        (idx),
    .key_cur    (key_cur)
);

// File: tb/tb_cache_set_hash.sv
`timescale 1ns/1ps
module tb_cache_set_hash;
    localparam int A  = 20;
    localparam int K  = 16;
    localparam int I  = 5;
    localparam int O  = 4;
    localparam int P  = 32;
    localparam int RW = 5;
    localparam int CW = 5 * P + K;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         key_load = 1'b0;
    logic [K-1:0] key_in = '0;
    logic         addr_valid = 1'b0;
    logic [A-1:0] addr = '0;
    logic         idx_valid;
    logic [I-1:0] idx;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [K-1:0] mkey = '0;
    logic [I-1:0] last_idx = '0;

    always #10 clk = ~clk;

    cache_set_hash #(.ADDR_W(A), .KEY_W(K), .IDX_W(I), .OFFS_W(O)) dut (
        .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_in(key_in),
        .addr_valid(addr_valid), .addr(addr), .idx_valid(idx_valid), .idx(idx)
    );

    function automatic logic [P-1:0] rotl_ref(logic [P-1:0] v, int amt);
        logic [P-1:0] r;
        for (int i = 0; i < P; i++) r[(i + amt) % P] = v[i];
        return r;
    endfunction

    function automatic logic [I-1:0] fold_ref(logic [CW-1:0] c);
        logic [I-1:0] r = '0;
        for (int i = 0; i < CW; i++) r[i % I] = r[i % I] ^ c[i];
        return r;
    endfunction

    function automatic logic [I-1:0] hash_ref(logic [A-1:0] a, logic [K-1:0] k);
        logic [P-1:0] p;
        p = '0;
        p[A-1:0] = a;
        return fold_ref({rotl_ref(p, int'(k[4:0])), rotl_ref(p, int'(k[9:5])),
                         rotl_ref(p, int'(a[O+4:O])), rotl_ref(p, int'(a[O+9:O+5])),
                         p, k});
    endfunction

    task automatic chk(string tag, logic [I-1:0] act, logic [I-1:0] exp,
                       logic av, logic ev);
        checks++;
        if (act !== exp || av !== ev) begin
            failures++;
            $display("FAIL %s: idx=%0h valid=%0b expected idx=%0h valid=%0b",
                     tag, act, av, exp, ev);
        end
    endtask

    // present one lookup, compare one edge later
    task automatic look(string tag, logic [A-1:0] a);
        logic [I-1:0] e;
        addr = a; addr_valid = 1'b1;
        e = hash_ref(a, mkey);
        @(negedge clk);
        chk(tag, idx, e, idx_valid, 1'b1);
        last_idx = e;
    endtask

    task automatic load_key(logic [K-1:0] k);
        key_in = k; key_load = 1'b1; addr_valid = 1'b0;
        @(negedge clk);
        key_load = 1'b0;
        mkey = k;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [K-1:0] keys [4];
        logic [I-1:0] first;
        logic [K-1:0] k2;
        keys[0] = 16'h0000; keys[1] = 16'hA5C3; keys[2] = 16'h03FF; keys[3] = 16'h7E19;

        repeat (3) @(negedge clk);
        chk("R1 reset", idx, '0, idx_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", idx, '0, idx_valid, 1'b0);

        // R8: zero key, zero rotate fields (bits 13:4)
        for (int i = 0; i < 1024; i++) begin
            logic [A-1:0] a;
            logic [P-1:0] p;
            logic [I-1:0] e;
            a = A'(((i & 15)) | ((i >> 4) << 14));
            p = '0; p[A-1:0] = a;
            e = fold_ref({p, p, p, p, p, 16'h0000});
            addr = a; addr_valid = 1'b1;
            @(negedge clk);
            chk("R8 zero key", idx, e, idx_valid, 1'b1);
        end

        // R3/R4/R5: every address rotate field value under each key
        for (int k = 0; k < 4; k++) begin
            load_key(keys[k]);
            for (int f = 0; f < 1024; f++)
                look("R3/R4/R5 field sweep", A'((f << O) | ((f * 37) & 15) | (k << 16)));
            for (int n = 0; n < 2048; n++)
                look("R3/R4/R5 spread sweep", A'((n * 40503 + k * 977) & ((1 << A) - 1)));
        end

        // R4: each key rotate value with a fixed address
        for (int v = 0; v < 1024; v++) begin
            load_key(K'(v * 33 + 16'h8000));
            look("R4 key field sweep", 20'hB38E1);
        end

        // R9: invalid cycle holds idx, R2: valid drops one edge later
        look("R9 setup", 20'h12345);
        addr = 20'hFEDCB; addr_valid = 1'b0;
        @(negedge clk);
        chk("R9 hold when invalid", idx, last_idx, idx_valid, 1'b0);
        chk("R2 valid low lag", idx, last_idx, idx_valid, 1'b0);
        look("R2 valid high lag", 20'h0F0F0);

        // R6: key_in ignored without load
        key_in = 16'hFFFF;
        look("R6 key_in ignored", 20'h55AA3);
        key_in = 16'h1234;
        look("R6 key_in ignored 2", 20'h0ACE1);

        // R6: address on the load edge still uses the old key
        begin
            logic [I-1:0] e;
            addr = 20'h3C3C3; addr_valid = 1'b1;
            key_in = 16'h5A17; key_load = 1'b1;
            e = hash_ref(20'h3C3C3, mkey);
            @(negedge clk);
            key_load = 1'b0;
            chk("R6 load edge uses old key", idx, e, idx_valid, 1'b1);
            mkey = 16'h5A17;
            look("R6 new key applies next", 20'h3C3C3);
        end

        // R7: a different key changes the index of a fixed address
        load_key(16'h0001);
        look("R7 base", 20'h9A4F0);
        first = idx;
        k2 = 16'h0002;
        while (hash_ref(20'h9A4F0, k2) == hash_ref(20'h9A4F0, 16'h0001)) k2 = k2 + 1;
        load_key(k2);
        look("R7 rekeyed", 20'h9A4F0);
        checks++;
        if (idx === first) begin
            failures++;
            $display("FAIL R7: idx=%0h expected not %0h", idx, first);
        end

        // R1: reset mid-run clears outputs and key
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        addr_valid = 1'b0;
        chk("R1 mid-run reset", idx, '0, idx_valid, 1'b0);
        mkey = '0;
        look("R1 key cleared", 20'h9A4F0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule